// File: doc/BRIEF.md
# Successive-Approximation Integer Square Root

This block returns the integer square root of an unsigned operand of even width 2N as an N-bit root. A one-cycle start request in the idle state captures the operand and clears a trial root. The engine then walks one trial bit per clock, from the most significant root bit down to the least significant. For each step it forms the candidate root with that bit set and squares it to a full 2N-bit product. It keeps the bit when the square does not exceed the operand and drops it when the square is larger. An exact match ends the search at once. Once the lowest bit has been tried, the search ends in any case. The final root is copied into an output register, and a one-cycle done pulse marks it.

The controller has three states. ST_IDLE waits for a start. ST_TRIAL performs one trial bit per cycle. ST_FINISH copies the root to the output register. There are four transitions. IDLE_TO_TRIAL is taken on an accepted start. TRIAL_STAY is taken while lower bits remain and no exact match has occurred. TRIAL_TO_FINISH is taken on an exact match or after the last bit. FINISH_TO_IDLE is unconditional. A start that arrives outside ST_IDLE is dropped.

Top module: `isqrt_sar`

## Requirements
- R1: After reset, busy_o, done_o and root_o are all 0.
- R2: A start_i seen at a clock edge while the block is idle captures x_i at that edge, and busy_o is 1 from the next cycle until the result is issued.
- R3: For every operand x, the root issued with done_o satisfies root*root <= x < (root+1)*(root+1).
- R4: An operand of 0 gives root 0. The all-ones operand gives 2^N-1. The squares are formed at full 2N-bit width, so they never wrap.
- R5: Trial bits run from root bit N-1 down to bit 0, one per cycle. For an operand that is not a perfect square, and for operand 0, done_o rises N+1 clock edges after the start edge.
- R6: For a nonzero perfect square r*r, the search stops on the trial of the lowest set bit b of r. done_o then rises N-b+1 edges after the start edge.
- R7: done_o is high for exactly one cycle. root_o holds its value until the next result is issued.
- R8: A start_i seen while busy_o is 1 is ignored. The running result and its timing are unchanged, and it produces no second done pulse.
- R9: A start_i seen in the cycle where done_o is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; sampled only while idle |
| x_i | input | 2N | Unsigned operand, captured on an accepted start |
| busy_o | output | 1 | High while a root is being computed |
| done_o | output | 1 | One-cycle pulse marking a new root_o |
| root_o | output | N | Registered integer square root |

## Verification
Two functions can fall in the same cycle, and both cases are provoked deliberately.

The first case is the exact-match stop and the lowest-bit stop arriving together. Perfect squares of odd roots, such as 9 and 65025, do this. The bench checks that the root is correct and that the latency is exactly N+1.

The second case is a new start landing in the cycle where done_o is high. A second request is driven during the done cycle of the first. The bench expects the first root on that cycle and the second root, with its own correct latency, afterwards.

A start pushed mid-search, with a different operand, must leave the first result and its latency unchanged and produce no extra done pulse.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRIAL  = 2'd1,
        ST_FINISH = 2'd2
    } sq_state_t;
endpackage

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
    import isqrt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    input  logic hit_i,
    output logic load_o,
    output logic step_o,
    output logic fin_o,
    output logic busy_o
);
    sq_state_t state_q;
    sq_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start_i ? ST_TRIAL : ST_IDLE;
            ST_TRIAL:  state_d = (hit_i || last_i) ? ST_FINISH : ST_TRIAL;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        fin_o  = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
                busy_o = 1'b0;
            end
            ST_TRIAL:  step_o = 1'b1;
            ST_FINISH: fin_o  = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    // R2: an accepted start always enters the trial state
    a_r2_load_enters_trial: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state_q == ST_TRIAL));

    // R6: an exact match from the datapath ends the search on the next edge
    a_r6_hit_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && hit_i) |=> (state_q == ST_FINISH));
endmodule

// File: rtl/isqrt_trial.sv
module isqrt_trial #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [2*N-1:0] x_i,
    output logic           last_o,
    output logic           hit_o,
    output logic [N-1:0]   y_o,
    output logic [2*N-1:0] x_q_o
);
    localparam int W = 2 * N;

    logic [W-1:0] x_q;
    logic [N-1:0] y_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] cand;
    logic [W-1:0] cand_ext;
    logic [W-1:0] pp [N];
    logic [W-1:0] sq;
    logic         over;

    assign cand     = y_q | mask_q;
    assign cand_ext = {{N{1'b0}}, cand};

    // shift-and-add squarer, full 2N-bit product
    for (genvar i = 0; i < N; i++) begin : g_pp
        assign pp[i] = cand[i] ? (cand_ext << i) : '0;
    end

    always_comb begin
        sq = '0;
        for (int k = 0; k < N; k++) begin
            sq = sq + pp[k];
        end
    end

    assign over   = sq > x_q;
    assign hit_o  = step_i && (sq == x_q);
    assign last_o = mask_q[0];
    assign y_o    = y_q;
    assign x_q_o  = x_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            mask_q <= '0;
        end else if (load_i) begin
            x_q    <= x_i;
            y_q    <= '0;
            mask_q <= {1'b1, {(N-1){1'b0}}};
        end else if (step_i) begin
            if (!over) begin
                y_q <= cand;
            end
            mask_q <= mask_q >> 1;
        end
    end

    // R3: the partial root never squares above the operand during the search
    logic [W-1:0] y_ext;
    assign y_ext = {{N{1'b0}}, y_q};
    a_r3_trial_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> ((y_ext * y_ext) <= x_q));

    // R5: exactly one trial bit is live while stepping
    a_r5_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> $onehot0(mask_q) && (mask_q != '0));
endmodule

// File: rtl/isqrt_outreg.sv
module isqrt_outreg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fin_i,
    input  logic [N-1:0] y_i,
    output logic [N-1:0] root_o,
    output logic         done_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                root_o <= y_i;
            end
        end
    end

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: root holds between results
    a_r7_root_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(root_o));
endmodule

// File: rtl/isqrt_sar.sv
module isqrt_sar #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*N-1:0] x_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [N-1:0]   root_o
);
    localparam int W  = 2 * N;
    localparam int CW = $clog2(N + 3) + 1;

    logic         load;
    logic         step;
    logic         fin;
    logic         last;
    logic         hit;
    logic [N-1:0] y;
    logic [W-1:0] x_q;

    isqrt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .last_i  (last),
        .hit_i   (hit),
        .load_o  (load),
        .step_o  (step),
        .fin_o   (fin),
        .busy_o  (busy_o)
    );

    isqrt_trial #(.N(N)) u_trial (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .x_i    (x_i),
        .last_o (last),
        .hit_o  (hit),
        .y_o    (y),
        .x_q_o  (x_q)
    );

    isqrt_outreg #(.N(N)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .fin_i  (fin),
        .y_i    (y),
        .root_o (root_o),
        .done_o (done_o)
    );

    // latency window counter for the checks below
    logic [CW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            lat_q <= '0;
        end else if (busy_o && (lat_q != {CW{1'b1}})) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R5: result issued no later than N+1 edges after the start edge
    a_r5_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q <= CW'(N + 1)));

    // R3: issued root is the floor of the square root of the held operand
    logic [W:0] r_ext;
    logic [W:0] r1_ext;
    assign r_ext  = {{(N+1){1'b0}}, root_o};
    assign r1_ext = r_ext + 1'b1;
    a_r3_floor_root: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (((r_ext * r_ext) <= {1'b0, x_q}) &&
                    ((r1_ext * r1_ext) > {1'b0, x_q})));

    // R8: a start while busy does not disturb the captured operand
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(x_q));
endmodule

// File: tb/isqrt_sar_bench.sv
module isqrt_sar_bench;
    localparam int N = 8;
    localparam int W = 2 * N;
    localparam int NV = 17;

    // {operand, expected root}
    localparam logic [W+N-1:0] VEC [NV] = '{
        {16'd0,     8'd0},
        {16'd1,     8'd1},
        {16'd2,     8'd1},
        {16'd3,     8'd1},
        {16'd4,     8'd2},
        {16'd9,     8'd3},
        {16'd15,    8'd3},
        {16'd16,    8'd4},
        {16'd255,   8'd15},
        {16'd256,   8'd16},
        {16'd1000,  8'd31},
        {16'd12345, 8'd111},
        {16'd16384, 8'd128},
        {16'd40000, 8'd200},
        {16'd65024, 8'd254},
        {16'd65025, 8'd255},
        {16'd65535, 8'd255}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] x_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [N-1:0] root_o;

    int checks = 0;
    int errors = 0;
    int lat;
    bit timed_out;

    always #4 clk = ~clk;

    isqrt_sar #(.N(N)) u_isqrt_sar (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i),
        .busy_o(busy_o), .done_o(done_o), .root_o(root_o)
    );

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int exp_lat(input int x, input int r);
        int b;
        if (x == 0 || r * r != x) return N + 1;
        b = 0;
        while (((r >> b) & 1) == 0) b++;
        return N - b + 1;
    endfunction

    // wait for done; lat counts edges after the start edge
    task automatic wait_done();
        timed_out = 0;
        while (!done_o) begin
            @(negedge clk);
            lat++;
            if (lat > 4 * N) begin
                timed_out = 1;
                break;
            end
        end
        if (timed_out) check("watchdog", 0, 1);
    endtask

    task automatic run(input logic [W-1:0] x);
        start_i = 1'b1;
        x_i     = x;
        @(negedge clk);
        start_i = 1'b0;
        x_i     = '0;
        lat     = 0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 root", root_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            int xv;
            int rv;
            xv = int'(VEC[i][W+N-1:N]);
            rv = int'(VEC[i][N-1:0]);
            run(VEC[i][W+N-1:N]);
            check("R3 root", root_o, rv);
            if (xv == 0) check("R4 zero", root_o, 0);
            if (xv == 65535) check("R4 all ones", root_o, 255);
            if (exp_lat(xv, rv) == N + 1) check("R5 latency", lat, N + 1);
            else check("R6 early stop latency", lat, exp_lat(xv, rv));
            @(negedge clk);
            check("R7 done width", done_o, 0);
            check("R7 root held", root_o, rv);
            check("R2 idle after", busy_o, 0);
        end

        // R2: busy during search
        start_i = 1'b1; x_i = 16'd50;
        @(negedge clk);
        start_i = 1'b0; x_i = '0;
        check("R2 busy", busy_o, 1);
        lat = 0;
        wait_done();
        check("R2 captured operand", root_o, 7);
        @(negedge clk);

        // R8: start during search with other operand
        start_i = 1'b1; x_i = 16'd100;
        @(negedge clk);
        start_i = 1'b0; lat = 0;
        @(negedge clk); lat++;
        start_i = 1'b1; x_i = 16'd65535;
        @(negedge clk); lat++;
        start_i = 1'b0; x_i = '0;
        wait_done();
        check("R8 root unchanged", root_o, 10);
        check("R8 latency unchanged", lat, N);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < N + 4; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check("R8 no second done", extra, 0);
        end

        // R9: start in the done cycle
        run(16'd99);
        check("R9 first root", root_o, 9);
        run(16'd4096);
        check("R9 second root", root_o, 64);
        check("R9 second latency", lat, exp_lat(4096, 64));
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule